// File: doc/BRIEF.md
# Key-Protected Voltage-ID Passthrough Controller

This block sits in the path from a processor's voltage-identification pins to a voltage regulator's VID inputs. After reset it holds a captured copy of the processor's code and presents it unchanged, so the regulator sees what the processor asked for. The input code is captured again whenever a reset-out pulse begins.

A host reaches the block through a byte-wide register write port: an index, a data byte and a write strobe. Two ways of changing the voltage are available. In the first, the host replaces the output code with a programmed value. This works only after four key bytes have been written to the key register in order. A separate exit byte locks the block again. In the second, a signed offset is added to the captured code on the fly. The sum is clamped to the legal code range.

A reset-out pulse or a processor-socket change returns the block to passthrough. The mode bits that matter most can only be written while the block is unlocked.

Top module: `vid_guard_ctrl`

## Requirements
- R1: After reset the output equals the input code captured during reset. Later changes on `vid_in` do not reach the output until the next capture.
- R2: Writing 0x32, 0x5D, 0x42, 0xAC in order to the key register (index 0x13) sets `key_ok` to 1. `key_ok` rises only on the write of the last key byte.
- R3: A wrong byte during the key sequence restarts matching. If that wrong byte equals the first key byte (0x32), it counts as the first byte of a new sequence.
- R4: Writing 0x35 to the key register clears `key_ok` in the following cycle.
- R5: Output-data register (index 0x12): bit 7 is the output enable and bits 5:0 are the code. The output shows that code only while the output enable is 1 and `key_ok` is 1.
- R6: The rising edge of `rstout_pulse` clears the output enable.
- R7: The rising edge of `rstout_pulse` captures `vid_in` again.
- R8: The rising edge of `slot_event` clears the output enable, the processor-select bit, the offset-mode bit and the 6-bit-mode bit.
- R9: Mode register (index 0x10): bit 0 enables offset mode, bit 1 enables 6-bit mode (reset value 1), bit 2 is the processor select, and bit 3 selects the wide offset. Bits 2:0 ignore writes while `key_ok` is 0. Bit 3 is always writable.
- R10: In offset mode the output is the captured code plus the offset register (index 0x11). The offset is a 5-bit two's-complement value taken from bits 4:0.
- R11: The offset sum saturates at 0 and at the largest code of the active width. It does not wrap.
- R12: With bit 3 of the mode register set, the offset is a 6-bit two's-complement value (bits 5:0, range -32 to +31).
- R13: With 6-bit mode off, output bit 5 is 0, and the captured code and the programmed code are treated as 5-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-good reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index |
| wr_data | input | 8 | Write data byte |
| vid_in | input | VID_W | Processor voltage-ID code |
| rstout_pulse | input | 1 | Reset-out pulse; a rising edge forces passthrough and recaptures the code |
| slot_event | input | 1 | Socket-occupied signal; a rising edge clears the protected mode bits |
| vid_out | output | VID_W | Code presented to the regulator |
| key_ok | output | 1 | 1 while the key is unlocked |
| out_en_o | output | 1 | Output-enable bit |
| cpu_sel_o | output | 1 | Processor-select bit |
| otf_en_o | output | 1 | Offset-mode bit |
| vrm10_o | output | 1 | 6-bit mode bit |

## Verification
The bench builds the block with its default width of six VID bits. At that width both offset encodings can be reached. So can bit-5 masking when 6-bit mode is switched off. The bench uses this to check the clamp against both the 5-bit ceiling (0x1F) and the 6-bit ceiling (0x3F), and the clamp at zero with the most negative narrow offset. It also shows that a value of 0x20 in the offset register means -32 only when the wide offset is selected.

// File: rtl/vid_guard_pkg.sv
package vid_guard_pkg;

    localparam int DATA_W  = 8;
    localparam int KEY_LEN = 4;

    localparam logic [DATA_W-1:0] IDX_MODE   = 8'h10;
    localparam logic [DATA_W-1:0] IDX_OFFSET = 8'h11;
    localparam logic [DATA_W-1:0] IDX_ODATA  = 8'h12;
    localparam logic [DATA_W-1:0] IDX_KEY    = 8'h13;

    localparam logic [DATA_W-1:0] KEY_EXIT = 8'h35;

    // Mode register: wide offset, processor select, 6-bit mode, offset mode
    typedef struct packed {
        logic wide;
        logic cpu_sel;
        logic vrm10;
        logic otf;
    } mode_t;

    localparam mode_t MODE_RESET = '{wide: 1'b0, cpu_sel: 1'b0, vrm10: 1'b1, otf: 1'b0};

    function automatic logic [DATA_W-1:0] key_byte(input int pos);
        case (pos)
            0:       key_byte = 8'h32;
            1:       key_byte = 8'h5D;
            2:       key_byte = 8'h42;
            default: key_byte = 8'hAC;
        endcase
    endfunction

endpackage

// File: rtl/vid_key_fsm.sv
module vid_key_fsm
    import vid_guard_pkg::*;
#(
    parameter int LEN = KEY_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              unlocked
);

    localparam int CNT_W = $clog2(LEN + 1);
    localparam logic [CNT_W-1:0] CNT_OPEN = CNT_W'(LEN);

    logic [CNT_W-1:0] matched;

    always_ff @(posedge clk) begin
        if (rst) begin
            matched <= '0;
        end else if (key_wr) begin
            if (key_data == KEY_EXIT)
                matched <= '0;
            else if (matched == CNT_OPEN)
                matched <= matched;
            else if (key_data == key_byte(int'(matched)))
                matched <= matched + 1'b1;
            else if (key_data == key_byte(0))
                matched <= CNT_W'(1);
            else
                matched <= '0;
        end
    end

    assign unlocked = (matched == CNT_OPEN);

    a_r4_exit_locks: assert property (@(posedge clk) disable iff (rst)
        (key_wr && key_data == KEY_EXIT) |=> !unlocked);

    a_r2_open_on_last_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(key_wr && key_data == key_byte(LEN - 1)));

endmodule

// File: rtl/vid_offset_sat.sv
module vid_offset_sat #(
    parameter int W = 6
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] ofs,
    input  logic         wide,
    input  logic [W-1:0] lim,
    output logic [W-1:0] res
);

    localparam int SW = W + 2;

    logic signed [SW-1:0] ofs_ext;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lim_s;

    always_comb begin
        if (wide)
            ofs_ext = {{2{ofs[W-1]}}, ofs};
        else
            ofs_ext = {{3{ofs[W-2]}}, ofs[W-2:0]};
        sum   = $signed({2'b00, base}) + ofs_ext;
        lim_s = $signed({2'b00, lim});
        if (sum < 0)
            res = '0;
        else if (sum > lim_s)
            res = lim;
        else
            res = sum[W-1:0];
    end

endmodule

// File: rtl/vid_guard_ctrl.sv
module vid_guard_ctrl
    import vid_guard_pkg::*;
#(
    parameter int VID_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [VID_W-1:0]  vid_in,
    input  logic              rstout_pulse,
    input  logic              slot_event,
    output logic [VID_W-1:0]  vid_out,
    output logic              key_ok,
    output logic              out_en_o,
    output logic              cpu_sel_o,
    output logic              otf_en_o,
    output logic              vrm10_o
);

    localparam logic [VID_W-1:0] LIM_FULL   = {VID_W{1'b1}};
    localparam logic [VID_W-1:0] LIM_NARROW = {1'b0, {(VID_W-1){1'b1}}};

    mode_t            mode;
    logic [VID_W-1:0] ofs_r;
    logic [VID_W-1:0] odata_r;
    logic [VID_W-1:0] vid_lat;
    logic             out_en;
    logic             rso_q;
    logic             slot_q;
    logic             rso_rise;
    logic             slot_rise;
    logic             unlocked;
    logic [VID_W-1:0] lim;
    logic [VID_W-1:0] base;
    logic [VID_W-1:0] shifted;

    assign rso_rise  = rstout_pulse & ~rso_q;
    assign slot_rise = slot_event & ~slot_q;

    vid_key_fsm #(.LEN(KEY_LEN)) u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr_en && wr_idx == IDX_KEY),
        .key_data (wr_data),
        .unlocked (unlocked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_RESET;
            ofs_r   <= '0;
            odata_r <= '0;
            out_en  <= 1'b0;
            vid_lat <= vid_in;
            rso_q   <= rstout_pulse;
            slot_q  <= slot_event;
        end else begin
            rso_q  <= rstout_pulse;
            slot_q <= slot_event;
            if (rso_rise)
                vid_lat <= vid_in;
            if (wr_en) begin
                case (wr_idx)
                    IDX_MODE: begin
                        mode.wide <= wr_data[3];
                        if (unlocked) begin
                            mode.cpu_sel <= wr_data[2];
                            mode.vrm10   <= wr_data[1];
                            mode.otf     <= wr_data[0];
                        end
                    end
                    IDX_OFFSET: ofs_r <= wr_data[VID_W-1:0];
                    IDX_ODATA: begin
                        odata_r <= wr_data[VID_W-1:0];
                        out_en  <= wr_data[DATA_W-1];
                    end
                    default: ;
                endcase
            end
            if (slot_rise) begin
                mode.cpu_sel <= 1'b0;
                mode.vrm10   <= 1'b0;
                mode.otf     <= 1'b0;
                out_en       <= 1'b0;
            end
            if (rso_rise)
                out_en <= 1'b0;
        end
    end

    assign lim  = mode.vrm10 ? LIM_FULL : LIM_NARROW;
    assign base = vid_lat & lim;

    vid_offset_sat #(.W(VID_W)) u_sat (
        .base (base),
        .ofs  (ofs_r),
        .wide (mode.wide),
        .lim  (lim),
        .res  (shifted)
    );

    always_comb begin
        if (out_en && unlocked)
            vid_out = odata_r & lim;
        else if (mode.otf)
            vid_out = shifted;
        else
            vid_out = base;
    end

    assign key_ok    = unlocked;
    assign out_en_o  = out_en;
    assign cpu_sel_o = mode.cpu_sel;
    assign otf_en_o  = mode.otf;
    assign vrm10_o   = mode.vrm10;

    a_r6_rstout_drops_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(rstout_pulse) |=> !out_en_o);

    a_r8_socket_clears_modes: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_event) |=> !(out_en_o || cpu_sel_o || otf_en_o || vrm10_o));

    a_r9_locked_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_MODE && !key_ok && !$rose(slot_event))
        |=> $stable({cpu_sel_o, otf_en_o, vrm10_o}));

    a_r13_narrow_top_bit: assert property (@(posedge clk) disable iff (rst)
        !vrm10_o |-> !vid_out[VID_W-1]);

endmodule

// File: tb/vid_guard_ctrl_test.sv
module vid_guard_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] vid_in = 6'h2A;
    logic       rstout_pulse = 1'b0;
    logic       slot_event = 1'b0;
    logic [5:0] vid_out;
    logic       key_ok, out_en_o, cpu_sel_o, otf_en_o, vrm10_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string      tag;
        logic [5:0] vid;
        logic       key;
        logic [3:0] flags;   // {out_en, cpu_sel, otf, vrm10}
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    vid_guard_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .vid_in(vid_in), .rstout_pulse(rstout_pulse), .slot_event(slot_event),
        .vid_out(vid_out), .key_ok(key_ok), .out_en_o(out_en_o),
        .cpu_sel_o(cpu_sel_o), .otf_en_o(otf_en_o), .vrm10_o(vrm10_o)
    );

    // Monitor: pops one expected item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [3:0] got_f;
                e = exp_q.pop_front();
                got_f = {out_en_o, cpu_sel_o, otf_en_o, vrm10_o};
                n_cmp++;
                if (vid_out !== e.vid || key_ok !== e.key || got_f !== e.flags) begin
                    n_bad++;
                    $display("FAIL %s: vid=%h key=%b flags=%b expected vid=%h key=%b flags=%b",
                             e.tag, vid_out, key_ok, got_f, e.vid, e.key, e.flags);
                end
            end
        end
    end

    task automatic expect_now(input string tag, input logic [5:0] v,
                              input logic k, input logic [3:0] f);
        exp_t e;
        e.tag = tag; e.vid = v; e.key = k; e.flags = f;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_rstout(input logic [5:0] v);
        @(negedge clk);
        vid_in = v; rstout_pulse = 1'b1;
        @(negedge clk);
        rstout_pulse = 1'b0;
    endtask

    task automatic unlock();
        wr(8'h13, 8'h32); wr(8'h13, 8'h5D); wr(8'h13, 8'h42); wr(8'h13, 8'hAC);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_now("R1 reset bypass", 6'h2A, 1'b0, 4'b0001);
        vid_in = 6'h15;
        @(negedge clk);
        expect_now("R1 input change held off", 6'h2A, 1'b0, 4'b0001);

        wr(8'h10, 8'h07);
        expect_now("R9 locked mode write ignored", 6'h2A, 1'b0, 4'b0001);

        wr(8'h12, 8'h85);
        expect_now("R5 enable without key", 6'h2A, 1'b0, 4'b1001);

        wr(8'h13, 8'h32); wr(8'h13, 8'h5D); wr(8'h13, 8'h99);
        wr(8'h13, 8'h42); wr(8'h13, 8'hAC);
        expect_now("R3 wrong byte restarts", 6'h2A, 1'b0, 4'b1001);

        wr(8'h13, 8'h32); wr(8'h13, 8'h32); wr(8'h13, 8'h5D);
        wr(8'h13, 8'h42);
        expect_now("R2 not open before last byte", 6'h2A, 1'b0, 4'b1001);
        wr(8'h13, 8'hAC);
        expect_now("R3 R5 restart on first byte then override", 6'h05, 1'b1, 4'b1001);

        wr(8'h13, 8'h35);
        expect_now("R4 exit key locks", 6'h2A, 1'b0, 4'b1001);
        unlock();
        expect_now("R2 unlock again", 6'h05, 1'b1, 4'b1001);

        pulse_rstout(6'h15);
        expect_now("R6 R7 rstout clears enable and recaptures", 6'h15, 1'b1, 4'b0001);

        wr(8'h10, 8'h07);
        wr(8'h11, 8'h03);
        expect_now("R10 offset +3", 6'h18, 1'b1, 4'b0111);
        wr(8'h11, 8'h1E);
        expect_now("R10 offset -2", 6'h13, 1'b1, 4'b0111);

        pulse_rstout(6'h03);
        wr(8'h11, 8'h10);
        expect_now("R11 clamp at zero", 6'h00, 1'b1, 4'b0111);
        pulse_rstout(6'h3E);
        wr(8'h11, 8'h0F);
        expect_now("R11 clamp at 6-bit max", 6'h3F, 1'b1, 4'b0111);

        wr(8'h11, 8'h20);
        expect_now("R12 narrow reads 0x20 as zero", 6'h3E, 1'b1, 4'b0111);
        wr(8'h10, 8'h0F);
        expect_now("R12 wide offset -32", 6'h1E, 1'b1, 4'b0111);

        wr(8'h10, 8'h04);
        expect_now("R13 narrow mode masks bit 5", 6'h1E, 1'b1, 4'b0100);
        wr(8'h11, 8'h0F);
        wr(8'h10, 8'h05);
        expect_now("R11 R13 clamp at 5-bit max", 6'h1F, 1'b1, 4'b0110);

        wr(8'h12, 8'hA7);
        expect_now("R5 R13 override masked", 6'h07, 1'b1, 4'b1110);

        @(negedge clk); slot_event = 1'b1;
        @(negedge clk); slot_event = 1'b0;
        expect_now("R8 socket event clears modes", 6'h1E, 1'b1, 4'b0000);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule